// File: doc/BRIEF.md
# Two-Level Cache Inclusion Controller

This block models the tag side of a small first-level cache and a larger second-level cache. It has no data payloads. A controller sits in front of the pair and applies one of three inclusion policies, chosen per request. Each level keeps only a valid bit, a stored block address and replacement ages for every way. Requests carry a block address, so the byte offset has already been removed.

A request is accepted while the controller is idle. The controller looks the block up in both levels. It then finishes with a code that says where the block was found. Before that code appears it performs every fill, move, victim transfer and back-invalidation that the active policy demands. When neither level holds the block, a request/acknowledge handshake fetches it from memory. Two event strobes show cross-level effects as they happen, and each carries the affected block address:
- a back-invalidation of a first-level line;
- the transfer of a first-level victim into the second level.

Top module: `icp_cache_pair`

## Requirements
- R1: After synchronous reset, `req_ready` is 1, and `done`, `mem_req`, `binv_valid` and `vict_valid` are 0. `hit_lvl` is 0 and both levels are empty.
- R2: In every policy, a request that hits the first level completes with `hit_lvl` = 1. It makes no memory fetch and changes nothing in the second level.
- R3: In policy 0 (inclusive) and policy 2 (non-inclusive non-exclusive), a request that misses the first level but hits the second completes with `hit_lvl` = 2. The block is then installed in the first level and also stays in the second level.
- R4: In policies 0 and 2, a request that misses both levels completes with `hit_lvl` = 3. It makes exactly one memory fetch and installs the block in both levels.
- R5: In policy 0, when the second level evicts a block that the first level also holds, the first-level copy is invalidated. This raises `binv_valid` for one cycle with that block on `binv_addr`. A first-level eviction leaves the second level alone.
- R6: In policy 1 (exclusive), a second-level hit completes with `hit_lvl` = 2. The block moves into the first level and its second-level entry becomes invalid.
- R7: In policy 1, a request that misses both levels installs the block in the first level only. A valid first-level victim is written into the second level and raises `vict_valid` for one cycle with its address on `vict_addr`. This is the only way the second level gains entries.
- R8: In policy 2, and in the unused code 3 (which behaves as policy 2), neither strobe ever fires. Evictions at one level do not affect the other level.
- R9: Both levels choose their set from the low bits of the block address. Both use least-recently-used replacement, and an invalid way (lowest index first) is taken before any valid way is evicted. Geometry by default: first level 4 sets × 2 ways, second level 8 sets × 4 ways.
- R10: `mode_in` is sampled only when a request is accepted. Changes to it while a request is in progress have no effect on that request.
- R11: `mem_req` stays high with the request's block on `mem_addr` until `mem_ack` is seen. `done` pulses for one cycle when each request completes.
- R12: A block never occupies two ways of the same level, so a block that was just installed hits in that level on the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken while `req_ready` is high |
| req_addr | input | ADDR_W | Block address of the request |
| mode_in | input | 2 | Policy: 0 inclusive, 1 exclusive, 2 or 3 non-inclusive non-exclusive |
| req_ready | output | 1 | Controller idle, request can be taken |
| mem_req | output | 1 | Memory fetch request, held until acknowledged |
| mem_addr | output | ADDR_W | Block address being fetched |
| mem_ack | input | 1 | Memory fetch complete |
| done | output | 1 | One-cycle completion pulse |
| hit_lvl | output | 2 | Where the block was found: 1 first level, 2 second level, 3 memory |
| binv_valid | output | 1 | Back-invalidation strobe |
| binv_addr | output | ADDR_W | Block removed from the first level |
| vict_valid | output | 1 | Victim-to-second-level strobe |
| vict_addr | output | ADDR_W | Block moved from the first level into the second |

## Verification
The bench builds the block with a 6-bit block address, a 4×2 first level and an 8×4 second level. The whole address space of 64 blocks is therefore twice the second level's capacity and eight times the first level's. With this size, complete sequential sweeps, conflict patterns that keep to one set, and a hot-block pattern can all force every eviction path in a few dozen requests:
- second-level evictions of blocks still held in the first level;
- victims moving downward;
- least-recently-used ordering within one set.

Each policy, including the unused code, is swept from reset against an arithmetic model of both levels. Memory latency is varied, and `mode_in` is toggled during every request.

// File: rtl/icp_pkg.sv
package icp_pkg;

  typedef enum logic [1:0] {
    MD_INCL = 2'd0,
    MD_EXCL = 2'd1,
    MD_NINE = 2'd2,
    MD_RSVD = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_TOUCH = 2'd1,
    OP_INVAL = 2'd2,
    OP_FILL  = 2'd3
  } op_e;

  localparam logic [1:0] LVL_NONE = 2'd0;
  localparam logic [1:0] LVL_L1   = 2'd1;
  localparam logic [1:0] LVL_L2   = 2'd2;
  localparam logic [1:0] LVL_MEM  = 2'd3;

endpackage

// File: rtl/icp_level.sv
module icp_level
  import icp_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int SETS   = 4,
  parameter int WAYS   = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        lk_addr,
  input  op_e                      op,
  input  logic [$clog2(WAYS)-1:0]  op_way,
  output logic                     hit,
  output logic [$clog2(WAYS)-1:0]  hit_way,
  output logic                     vic_valid,
  output logic [$clog2(WAYS)-1:0]  vic_way,
  output logic [ADDR_W-1:0]        vic_addr
);

  localparam int IW = $clog2(SETS);
  localparam int WW = $clog2(WAYS);
  localparam logic [WW-1:0] OLDEST = WW'(WAYS - 1);

  logic [ADDR_W-1:0] tag_q   [SETS][WAYS];
  logic [WAYS-1:0]   valid_q [SETS];
  logic [WW-1:0]     age_q   [SETS][WAYS];

  logic [IW-1:0]   set_idx;
  logic [WAYS-1:0] match;
  logic [WW-1:0]   old_age;

  assign set_idx = lk_addr[IW-1:0];
  assign old_age = age_q[set_idx][op_way];

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++)
      match[w] = valid_q[set_idx][w] && (tag_q[set_idx][w] == lk_addr);
    for (int w = WAYS - 1; w >= 0; w--)
      if (match[w]) hit_way = WW'(w);
  end

  assign hit = |match;

  always_comb begin
    logic found;
    found   = 1'b0;
    vic_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!valid_q[set_idx][w] && !found) begin
        vic_way = WW'(w);
        found   = 1'b1;
      end
    end
    if (!found) begin
      for (int w = 0; w < WAYS; w++)
        if (age_q[set_idx][w] == OLDEST) vic_way = WW'(w);
    end
  end

  assign vic_valid = valid_q[set_idx][vic_way];
  assign vic_addr  = tag_q[set_idx][vic_way];

  // valid bits and replacement ages
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        for (int w = 0; w < WAYS; w++)
          age_q[s][w] <= WW'(w);
      end
    end else begin
      if (op == OP_TOUCH || op == OP_FILL) begin
        for (int w = 0; w < WAYS; w++) begin
          if (WW'(w) == op_way)
            age_q[set_idx][w] <= '0;
          else if (age_q[set_idx][w] < old_age)
            age_q[set_idx][w] <= age_q[set_idx][w] + 1'b1;
        end
      end
      if (op == OP_FILL)  valid_q[set_idx][op_way] <= 1'b1;
      if (op == OP_INVAL) valid_q[set_idx][op_way] <= 1'b0;
    end
  end

  // tag store: no reset, one write port
  always_ff @(posedge clk) begin
    if (op == OP_FILL) tag_q[set_idx][op_way] <= lk_addr;
  end

  AST_ONE_WAY_MATCH: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match)); // R12
  AST_FILL_ON_MISS: assert property (@(posedge clk) disable iff (rst)
    (op == OP_FILL) |-> !hit); // R12

endmodule

// File: rtl/icp_ctrl.sv
module icp_ctrl
  import icp_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int L1_WAYS = 2,
  parameter int L2_WAYS = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        req_valid,
  input  logic [ADDR_W-1:0]           req_addr,
  input  logic [1:0]                  mode_in,
  output logic                        req_ready,
  output logic                        mem_req,
  output logic [ADDR_W-1:0]           mem_addr,
  input  logic                        mem_ack,
  output logic                        done,
  output logic [1:0]                  hit_lvl,
  output logic                        binv_valid,
  output logic [ADDR_W-1:0]           binv_addr,
  output logic                        vict_valid,
  output logic [ADDR_W-1:0]           vict_addr,
  output logic [ADDR_W-1:0]           l1_lk_addr,
  output op_e                         l1_op,
  output logic [$clog2(L1_WAYS)-1:0]  l1_way,
  input  logic                        l1_hit,
  input  logic [$clog2(L1_WAYS)-1:0]  l1_hit_way,
  input  logic                        l1_vic_valid,
  input  logic [$clog2(L1_WAYS)-1:0]  l1_vic_way,
  input  logic [ADDR_W-1:0]           l1_vic_addr,
  output logic [ADDR_W-1:0]           l2_lk_addr,
  output op_e                         l2_op,
  output logic [$clog2(L2_WAYS)-1:0]  l2_way,
  input  logic                        l2_hit,
  input  logic [$clog2(L2_WAYS)-1:0]  l2_hit_way,
  input  logic                        l2_vic_valid,
  input  logic [$clog2(L2_WAYS)-1:0]  l2_vic_way,
  input  logic [ADDR_W-1:0]           l2_vic_addr
);

  typedef enum logic [2:0] {
    S_IDLE, S_LOOK, S_MEM, S_L2INS, S_L1INS, S_VIC
  } state_e;

  state_e            state;
  mode_e             mode_q;
  logic [ADDR_W-1:0] addr_q;
  logic [1:0]        pend_q;
  logic              done_q, binv_q, vict_q;
  logic [1:0]        lvl_q;
  logic [ADDR_W-1:0] binv_addr_q, vaddr_q;
  logic              is_incl, is_excl;

  assign is_incl   = (mode_q == MD_INCL);
  assign is_excl   = (mode_q == MD_EXCL);
  assign req_ready = (state == S_IDLE);
  assign mem_req   = (state == S_MEM);
  assign mem_addr  = addr_q;
  assign done      = done_q;
  assign hit_lvl   = lvl_q;
  assign binv_valid = binv_q;
  assign binv_addr  = binv_addr_q;
  assign vict_valid = vict_q;
  assign vict_addr  = vaddr_q;

  // lookup address steering: L1 probes the L2 victim during L2 install,
  // L2 looks at the L1 victim during victim placement
  assign l1_lk_addr = (state == S_L2INS) ? l2_vic_addr : addr_q;
  assign l2_lk_addr = (state == S_VIC)   ? vaddr_q     : addr_q;

  always_comb begin
    l1_op  = OP_NONE;
    l1_way = '0;
    l2_op  = OP_NONE;
    l2_way = '0;
    case (state)
      S_LOOK: begin
        if (l1_hit) begin
          l1_op  = OP_TOUCH;
          l1_way = l1_hit_way;
        end else if (l2_hit) begin
          l2_op  = is_excl ? OP_INVAL : OP_TOUCH;
          l2_way = l2_hit_way;
        end
      end
      S_L2INS: begin
        l2_op  = OP_FILL;
        l2_way = l2_vic_way;
        if (is_incl && l2_vic_valid && l1_hit) begin
          l1_op  = OP_INVAL;
          l1_way = l1_hit_way;
        end
      end
      S_L1INS: begin
        l1_op  = OP_FILL;
        l1_way = l1_vic_way;
      end
      S_VIC: begin
        if (l2_hit) begin
          l2_op  = OP_TOUCH;
          l2_way = l2_hit_way;
        end else begin
          l2_op  = OP_FILL;
          l2_way = l2_vic_way;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_IDLE;
      mode_q      <= MD_INCL;
      addr_q      <= '0;
      pend_q      <= LVL_NONE;
      done_q      <= 1'b0;
      binv_q      <= 1'b0;
      vict_q      <= 1'b0;
      lvl_q       <= LVL_NONE;
      binv_addr_q <= '0;
      vaddr_q     <= '0;
    end else begin
      done_q <= 1'b0;
      binv_q <= 1'b0;
      vict_q <= 1'b0;
      case (state)
        S_IDLE: begin
          if (req_valid) begin
            addr_q <= req_addr;
            mode_q <= mode_e'(mode_in);
            state  <= S_LOOK;
          end
        end
        S_LOOK: begin
          if (l1_hit) begin
            done_q <= 1'b1;
            lvl_q  <= LVL_L1;
            state  <= S_IDLE;
          end else if (l2_hit) begin
            pend_q <= LVL_L2;
            state  <= S_L1INS;
          end else begin
            pend_q <= LVL_MEM;
            state  <= S_MEM;
          end
        end
        S_MEM: begin
          if (mem_ack) state <= is_excl ? S_L1INS : S_L2INS;
        end
        S_L2INS: begin
          if (is_incl && l2_vic_valid && l1_hit) begin
            binv_q      <= 1'b1;
            binv_addr_q <= l2_vic_addr;
          end
          state <= S_L1INS;
        end
        S_L1INS: begin
          if (is_excl && l1_vic_valid) begin
            vict_q  <= 1'b1;
            vaddr_q <= l1_vic_addr;
            state   <= S_VIC;
          end else begin
            done_q <= 1'b1;
            lvl_q  <= pend_q;
            state  <= S_IDLE;
          end
        end
        S_VIC: begin
          done_q <= 1'b1;
          lvl_q  <= pend_q;
          state  <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> mem_req); // R11
  AST_BINV_MODE: assert property (@(posedge clk) disable iff (rst)
    binv_valid |-> (mode_q == MD_INCL)); // R5
  AST_VICT_MODE: assert property (@(posedge clk) disable iff (rst)
    vict_valid |-> (mode_q == MD_EXCL)); // R7
  AST_NINE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MD_NINE || mode_q == MD_RSVD) |-> !(binv_valid || vict_valid)); // R8
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (rst)
    !req_ready |=> $stable(mode_q)); // R10
  AST_L1HIT_DONE: assert property (@(posedge clk) disable iff (rst)
    (state == S_LOOK && l1_hit) |=> (done && hit_lvl == LVL_L1 && !mem_req)); // R2

endmodule

// File: rtl/icp_cache_pair.sv
module icp_cache_pair
  import icp_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int L1_SETS = 4,
  parameter int L1_WAYS = 2,
  parameter int L2_SETS = 8,
  parameter int L2_WAYS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        mode_in,
  output logic              req_ready,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  output logic              done,
  output logic [1:0]        hit_lvl,
  output logic              binv_valid,
  output logic [ADDR_W-1:0] binv_addr,
  output logic              vict_valid,
  output logic [ADDR_W-1:0] vict_addr
);

  localparam int W1 = $clog2(L1_WAYS);
  localparam int W2 = $clog2(L2_WAYS);

  logic [ADDR_W-1:0] l1_lk_addr, l2_lk_addr, l1_vic_addr, l2_vic_addr;
  op_e               l1_op, l2_op;
  logic [W1-1:0]     l1_way, l1_hit_way, l1_vic_way;
  logic [W2-1:0]     l2_way, l2_hit_way, l2_vic_way;
  logic              l1_hit, l1_vic_valid, l2_hit, l2_vic_valid;

  icp_ctrl #(.ADDR_W(ADDR_W), .L1_WAYS(L1_WAYS), .L2_WAYS(L2_WAYS)) u_ctrl (
    .clk, .rst, .req_valid, .req_addr, .mode_in, .req_ready,
    .mem_req, .mem_addr, .mem_ack, .done, .hit_lvl,
    .binv_valid, .binv_addr, .vict_valid, .vict_addr,
    .l1_lk_addr, .l1_op, .l1_way, .l1_hit, .l1_hit_way,
    .l1_vic_valid, .l1_vic_way, .l1_vic_addr,
    .l2_lk_addr, .l2_op, .l2_way, .l2_hit, .l2_hit_way,
    .l2_vic_valid, .l2_vic_way, .l2_vic_addr
  );

  icp_level #(.ADDR_W(ADDR_W), .SETS(L1_SETS), .WAYS(L1_WAYS)) u_l1 (
    .clk, .rst, .lk_addr(l1_lk_addr), .op(l1_op), .op_way(l1_way),
    .hit(l1_hit), .hit_way(l1_hit_way), .vic_valid(l1_vic_valid),
    .vic_way(l1_vic_way), .vic_addr(l1_vic_addr)
  );

  icp_level #(.ADDR_W(ADDR_W), .SETS(L2_SETS), .WAYS(L2_WAYS)) u_l2 (
    .clk, .rst, .lk_addr(l2_lk_addr), .op(l2_op), .op_way(l2_way),
    .hit(l2_hit), .hit_way(l2_hit_way), .vic_valid(l2_vic_valid),
    .vic_way(l2_vic_way), .vic_addr(l2_vic_addr)
  );

endmodule

// File: tb/sim_icp_cache_pair.sv
module sim_icp_cache_pair;

  localparam int AW = 6;
  localparam int NBLK = 1 << AW;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    mode_in = 2'd0;
  logic          mem_ack = 1'b0;
  logic          req_ready, mem_req, done, binv_valid, vict_valid;
  logic [AW-1:0] mem_addr, binv_addr, vict_addr;
  logic [1:0]    hit_lvl;

  icp_cache_pair #(.ADDR_W(AW), .L1_SETS(4), .L1_WAYS(2), .L2_SETS(8), .L2_WAYS(4)) u0 (
    .clk, .rst, .req_valid, .req_addr, .mode_in, .req_ready, .mem_req, .mem_addr,
    .mem_ack, .done, .hit_lvl, .binv_valid, .binv_addr, .vict_valid, .vict_addr
  );

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic chk(bit ok, string rq, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // ---------------- reference model of both levels ----------------
  int m_tag [2][8][4];
  bit m_v   [2][8][4];
  int m_age [2][8][4];
  int e_lvl, e_binv, e_vict;

  function automatic int nsets(int l); return (l != 0) ? 8 : 4; endfunction
  function automatic int nways(int l); return (l != 0) ? 4 : 2; endfunction

  task automatic m_clear();
    for (int l = 0; l < 2; l++)
      for (int s = 0; s < 8; s++)
        for (int w = 0; w < 4; w++) begin
          m_v[l][s][w] = 0; m_age[l][s][w] = w; m_tag[l][s][w] = 0;
        end
  endtask

  function automatic int m_look(int l, int a);
    int s = a % nsets(l);
    for (int w = 0; w < nways(l); w++)
      if (m_v[l][s][w] && m_tag[l][s][w] == a) return w;
    return -1;
  endfunction

  function automatic int m_vic(int l, int a);
    int s = a % nsets(l);
    for (int w = 0; w < nways(l); w++)
      if (!m_v[l][s][w]) return w;
    for (int w = 0; w < nways(l); w++)
      if (m_age[l][s][w] == nways(l) - 1) return w;
    return 0;
  endfunction

  task automatic m_touch(int l, int a, int w);
    int s = a % nsets(l);
    int old = m_age[l][s][w];
    for (int x = 0; x < nways(l); x++)
      if (x == w) m_age[l][s][x] = 0;
      else if (m_age[l][s][x] < old) m_age[l][s][x]++;
  endtask

  task automatic m_fill(int l, int a, int w);
    m_v[l][a % nsets(l)][w] = 1;
    m_tag[l][a % nsets(l)][w] = a;
    m_touch(l, a, w);
  endtask

  task automatic m_req(int a, int md);
    int w1, w2, v, va, w;
    e_binv = -1; e_vict = -1;
    w1 = m_look(0, a);
    if (w1 >= 0) begin
      e_lvl = 1; m_touch(0, a, w1);
      return;
    end
    w2 = m_look(1, a);
    if (w2 >= 0) begin
      e_lvl = 2;
      if (md == 1) m_v[1][a % 8][w2] = 0;
      else m_touch(1, a, w2);
    end else begin
      e_lvl = 3;
      if (md != 1) begin
        v = m_vic(1, a);
        if (m_v[1][a % 8][v] && md == 0) begin
          va = m_tag[1][a % 8][v];
          w = m_look(0, va);
          if (w >= 0) begin m_v[0][va % 4][w] = 0; e_binv = va; end
        end
        m_fill(1, a, v);
      end
    end
    v = m_vic(0, a);
    if (m_v[0][a % 4][v] && md == 1) e_vict = m_tag[0][a % 4][v];
    m_fill(0, a, v);
    if (e_vict >= 0) begin
      w = m_look(1, e_vict);
      if (w >= 0) m_touch(1, e_vict, w);
      else m_fill(1, e_vict, m_vic(1, e_vict));
    end
  endtask

  // ---------------- monitors and memory responder ----------------
  int n_binv, g_binv, n_vict, g_vict, n_fetch, g_maddr, lat, dcnt = 0;

  initial forever begin
    @(negedge clk);
    if (binv_valid) begin n_binv++; g_binv = int'(binv_addr); end
    if (vict_valid) begin n_vict++; g_vict = int'(vict_addr); end
    if (mem_ack) mem_ack = 1'b0;
    else if (mem_req) begin
      if (dcnt >= lat) begin
        mem_ack = 1'b1; n_fetch++; g_maddr = int'(mem_addr); dcnt = 0;
      end else dcnt++;
    end
  end

  // ---------------- request driver ----------------
  int g_lvl, nreq = 0;

  task automatic do_req(int a, int md);
    string base;
    m_req(a, md);
    n_binv = 0; n_vict = 0; n_fetch = 0; g_binv = -1; g_vict = -1; g_maddr = -1;
    lat = nreq % 4; nreq++;
    req_valid = 1'b1; req_addr = AW'(a); mode_in = 2'(md);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    mode_in = 2'(md ^ 1);      // R10: must not affect the running request
    while (!done) @(negedge clk);
    g_lvl = int'(hit_lvl);
    if (e_lvl == 1) base = "R2";
    else if (e_lvl == 2) base = (md == 1) ? "R6" : "R3";
    else base = (md == 1) ? "R7" : "R4";
    chk(g_lvl == e_lvl, {base, " R10 hit level"}, g_lvl, e_lvl);
    chk(n_fetch == ((e_lvl == 3) ? 1 : 0), "R11 fetch count", n_fetch, (e_lvl == 3) ? 1 : 0);
    if (e_lvl == 3) chk(g_maddr == a, "R11 fetch address", g_maddr, a);
    chk(n_binv == ((e_binv >= 0) ? 1 : 0), (md == 0) ? "R5 back-inval count" : "R8 back-inval count",
        n_binv, (e_binv >= 0) ? 1 : 0);
    if (e_binv >= 0) chk(g_binv == e_binv, "R5 back-inval address", g_binv, e_binv);
    chk(n_vict == ((e_vict >= 0) ? 1 : 0), (md == 1) ? "R7 victim count" : "R8 victim count",
        n_vict, (e_vict >= 0) ? 1 : 0);
    if (e_vict >= 0) chk(g_vict == e_vict, "R7 victim address", g_vict, e_vict);
  endtask

  task automatic do_reset();
    rst = 1'b1; req_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_clear();
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int unsigned x;
    do_reset();
    // R1 reset state
    chk(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);
    chk(done == 1'b0, "R1 done", int'(done), 0);
    chk(mem_req == 1'b0, "R1 mem_req", int'(mem_req), 0);
    chk(hit_lvl == 2'd0, "R1 hit level", int'(hit_lvl), 0);
    chk(binv_valid == 1'b0 && vict_valid == 1'b0, "R1 strobes", int'(binv_valid) + int'(vict_valid), 0);

    // R9 LRU in one first-level set (inclusive)
    do_req(0, 0); do_req(4, 0); do_req(0, 0); do_req(8, 0);
    do_req(0, 0); chk(g_lvl == 1, "R9 recent block kept", g_lvl, 1);
    do_req(4, 0); chk(g_lvl == 2, "R9 LRU block evicted", g_lvl, 2);
    // R12 freshly installed block hits on the next request
    do_req(21, 2); do_req(21, 2); chk(g_lvl == 1, "R12 single copy hit", g_lvl, 1);

    for (int md = 0; md < 4; md++) begin
      do_reset();
      for (int p = 0; p < 2; p++)
        for (int a = 0; a < NBLK; a++) do_req(a, md);
      for (int p = 0; p < 2; p++)
        for (int a = 0; a < NBLK; a += 4) do_req(a, md);
      for (int i = 1; i < 40; i++) begin
        do_req(0, md); do_req((8 * i) % NBLK, md);
      end
      x = 32'(md + 7);
      for (int i = 0; i < 200; i++) begin
        x = x * 32'd1103515245 + 32'd12345;
        do_req(int'((x >> 16) % NBLK), md);
      end
    end

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule